// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is one output cell of a small sum-of-products programmable logic device. It receives up to eight product-term results from the AND array and shapes them into a pin drive, a pin enable and a feedback bit that returns to the array. Two global architecture bits choose the device-wide mode. A per-cell I/O-select bit and a per-cell polarity bit refine the behaviour of each cell.

In the registered form, the OR of every product term passes through the polarity inversion into a D flip-flop. The pin shows the flop output, and a shared active-low enable pin gates it. In the combinatorial forms, one product term becomes the cell's own output enable and the others form the sum. The cell's position is fixed at build time. A cell on the outer edge of the device loses its input feedback when the device runs fully combinatorial.

The pin is presented as a data/enable pair, `pin_out_o` and `pin_oe_o`. A pad buffer outside the block floats the pin when the enable is low.

Top module: `pld_out_cell`

## Requirements
- R1: While `rst_ni` is low, the flop is cleared at once, without waiting for a clock edge. In the registered form, this shows as `pin_out_o`=0 and `fb_o`=0.
- R2: With `ac0_i`=0, the cell is unused: `pin_oe_o`=0, `pin_out_o`=0 and `fb_o`=0.
- R3: Registered form (`ac0_i`=1, `syn_i`=0, `ac1_i`=0): at each rising edge, the flop captures the OR of all eight terms `pt_i[7:0]`, after polarity. `pin_out_o` and `fb_o` both show the flop output.
- R4: Polarity: with `pol_i`=1 the cell value equals the OR sum, and with `pol_i`=0 it is the inverted sum. This holds in every form.
- R5: In the registered form, `pin_oe_o` equals the inverse of `oe_ni` (the shared enable is active low). In the combinatorial forms, `oe_ni` has no effect.
- R6: Combinatorial forms: `pin_out_o` is the OR of `pt_i[7:1]`, after polarity, with no clock delay. `pin_oe_o` equals `pt_i[0]`, and term 0 is not part of the sum.
- R7: A combinatorial I/O cell returns the pin input on `fb_o`. This applies to `ac1_i`=1 in registered mode, and to inner cells in complex mode.
- R8: Complex mode (`ac0_i`=1, `syn_i`=1): `ac1_i` has no effect on any output.
- R9: A cell built with `OUTER_CELL`=1 drives `fb_o`=0 in complex mode, whatever the pin input. In registered mode it behaves like any other cell.
- R10: `srst_i` high clears the flop at the next rising edge in any form. When the cell is not in the registered form and `srst_i` is low, the flop holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| srst_i | input | 1 | Synchronous clear of the cell flop |
| syn_i | input | 1 | Global mode bit: 0 registered, 1 complex |
| ac0_i | input | 1 | Global mode bit: must be 1 for an active cell |
| ac1_i | input | 1 | Per-cell I/O select: 0 registered, 1 combinatorial I/O |
| pol_i | input | 1 | Per-cell polarity: 1 active high, 0 active low |
| oe_ni | input | 1 | Shared active-low output-enable pin |
| pt_i | input | N_PT | Product-term results from the AND array |
| pin_in_i | input | 1 | Value currently seen on the cell's pin |
| pin_out_o | output | 1 | Data to the pin's tri-state buffer |
| pin_oe_o | output | 1 | Enable of the pin's tri-state buffer |
| fb_o | output | 1 | Feedback bit to the AND array |

## Verification
The bench sets only term 0 so that it separates the registered sum from the combinatorial sum. A design that used the wrong term count would drive the pin high in one form where it should be low. It toggles `ac1_i` in complex mode and drives the pin input on an edge cell: a decoder that did not ignore AC1, or that forgot the edge cell, would show pin feedback where 0 is due. It switches from complex mode back to the registered form between clock edges to expose a flop that loaded while it was meant to hold. It also drops the asynchronous reset between clock edges, which catches a reset that waits for a clock.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  // Behaviour chosen for one cell by the architecture bits
  typedef enum logic [1:0] {
    FORM_OFF  = 2'd0,  // unused cell
    FORM_REG  = 2'd1,  // registered output
    FORM_CIO  = 2'd2,  // combinatorial with pin feedback
    FORM_COUT = 2'd3   // combinatorial, output only
  } cell_form_e;

endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1] & rst_ni;

endmodule

// File: rtl/pld_mode_decode.sv
module pld_mode_decode
  import pld_cell_pkg::*;
#(
  parameter bit OUTER_CELL = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       syn_i,
  input  logic       ac0_i,
  input  logic       ac1_i,
  output cell_form_e form_o
);

  always_comb begin
    if (!ac0_i) begin
      form_o = FORM_OFF;
    end else if (!syn_i) begin
      form_o = ac1_i ? FORM_CIO : FORM_REG;
    end else begin
      form_o = OUTER_CELL ? FORM_COUT : FORM_CIO;
    end
  end

  // R8
  complex_never_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ac0_i && syn_i) |-> (form_o != FORM_REG));

endmodule

// File: rtl/pld_sum_term.sv
module pld_sum_term #(
  parameter int N_PT    = 8,
  parameter int OE_TERM = 0
) (
  input  logic [N_PT-1:0] pt_i,
  input  logic            pol_i,
  output logic            reg_val_o,
  output logic            comb_val_o,
  output logic            oe_term_o
);

  logic [N_PT-1:0] sum_mask;

  for (genvar g = 0; g < N_PT; g++) begin : g_mask
    assign sum_mask[g] = (g != OE_TERM);
  end

  always_comb begin
    reg_val_o  = (|pt_i) ^ ~pol_i;
    comb_val_o = (|(pt_i & sum_mask)) ^ ~pol_i;
    oe_term_o  = pt_i[OE_TERM];
  end

endmodule

// File: rtl/pld_cell_reg.sv
module pld_cell_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  logic q_d;
  logic q_en;

  always_comb begin
    q_en = ld_i | clr_i;
    q_d  = clr_i ? 1'b0 : d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else if (q_en) begin
      q_o <= q_d;
    end
  end

  // R10
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !clr_i) |=> $stable(q_o));

  // R3
  capture_d_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (q_o == $past(d_i)));

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int N_PT       = 8,
  parameter int OE_TERM    = 0,
  parameter bit OUTER_CELL = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            syn_i,
  input  logic            ac0_i,
  input  logic            ac1_i,
  input  logic            pol_i,
  input  logic            oe_ni,
  input  logic [N_PT-1:0] pt_i,
  input  logic            pin_in_i,
  output logic            pin_out_o,
  output logic            pin_oe_o,
  output logic            fb_o
);

  logic       rst_n_sync;
  cell_form_e form;
  logic       reg_val;
  logic       comb_val;
  logic       oe_term;
  logic       q;
  logic       ld;

  pld_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  pld_mode_decode #(.OUTER_CELL(OUTER_CELL)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .syn_i  (syn_i),
    .ac0_i  (ac0_i),
    .ac1_i  (ac1_i),
    .form_o (form)
  );

  pld_sum_term #(.N_PT(N_PT), .OE_TERM(OE_TERM)) u_sum (
    .pt_i       (pt_i),
    .pol_i      (pol_i),
    .reg_val_o  (reg_val),
    .comb_val_o (comb_val),
    .oe_term_o  (oe_term)
  );

  assign ld = (form == FORM_REG);

  pld_cell_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .ld_i   (ld),
    .clr_i  (srst_i),
    .d_i    (reg_val),
    .q_o    (q)
  );

  always_comb begin
    unique case (form)
      FORM_REG: begin
        pin_out_o = q;
        pin_oe_o  = ~oe_ni;
        fb_o      = q;
      end
      FORM_CIO: begin
        pin_out_o = comb_val;
        pin_oe_o  = oe_term;
        fb_o      = pin_in_i;
      end
      FORM_COUT: begin
        pin_out_o = comb_val;
        pin_oe_o  = oe_term;
        fb_o      = 1'b0;
      end
      default: begin
        pin_out_o = 1'b0;
        pin_oe_o  = 1'b0;
        fb_o      = 1'b0;
      end
    endcase
  end

  // R2
  unused_cell_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    !ac0_i |-> (!pin_oe_o && !fb_o && !pin_out_o));

  // R5
  shared_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (ac0_i && !syn_i && !ac1_i) |-> (pin_oe_o == !oe_ni));

  // R6
  term_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (ac0_i && (syn_i || ac1_i)) |-> (pin_oe_o == pt_i[OE_TERM]));

  // R9
  outer_no_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (OUTER_CELL && ac0_i && syn_i) |-> !fb_o);

  // R3
  reg_fb_matches_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (ac0_i && !syn_i && !ac1_i) |-> (fb_o == pin_out_o));

endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb;

  localparam int N_PT = 8;

  typedef struct {
    logic  out;
    logic  oe;
    logic  fb_in;
    logic  fb_out;
    string tag;
  } exp_item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            srst = 1'b1;
  logic            syn = 1'b0;
  logic            ac0 = 1'b1;
  logic            ac1 = 1'b0;
  logic            pol = 1'b1;
  logic            oe_n = 1'b0;
  logic [N_PT-1:0] pt = '1;
  logic            pin_in = 1'b0;

  logic out_a, oe_a, fb_a;
  logic out_b, oe_b, fb_b;

  int n_checks = 0;
  int n_fail = 0;
  logic exp_q = 1'b0;
  exp_item_t sb[$];

  always #2 clk = ~clk;

  pld_out_cell #(.N_PT(N_PT), .OUTER_CELL(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .syn_i(syn), .ac0_i(ac0),
    .ac1_i(ac1), .pol_i(pol), .oe_ni(oe_n), .pt_i(pt), .pin_in_i(pin_in),
    .pin_out_o(out_a), .pin_oe_o(oe_a), .fb_o(fb_a)
  );

  pld_out_cell #(.N_PT(N_PT), .OUTER_CELL(1'b1)) u_dut_outer (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .syn_i(syn), .ac0_i(ac0),
    .ac1_i(ac1), .pol_i(pol), .oe_ni(oe_n), .pt_i(pt), .pin_in_i(pin_in),
    .pin_out_o(out_b), .pin_oe_o(oe_b), .fb_o(fb_b)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Driver: applies one input set and pushes the expected outcome after the next edge
  task automatic drive(input string tag, input logic s_syn, input logic s_ac0, input logic s_ac1,
                       input logic s_pol, input logic s_oe_n, input logic [N_PT-1:0] s_pt,
                       input logic s_pin, input logic s_srst);
    exp_item_t it;
    logic reg_form, sum_all, sum_cmb, q_new;
    @(negedge clk);
    syn = s_syn; ac0 = s_ac0; ac1 = s_ac1; pol = s_pol;
    oe_n = s_oe_n; pt = s_pt; pin_in = s_pin; srst = s_srst;
    reg_form = s_ac0 && !s_syn && !s_ac1;
    sum_all  = |s_pt;
    sum_cmb  = |s_pt[N_PT-1:1];
    if (s_srst)        q_new = 1'b0;
    else if (reg_form) q_new = s_pol ? sum_all : !sum_all;
    else               q_new = exp_q;
    exp_q = q_new;
    if (!s_ac0) begin
      it.out = 1'b0; it.oe = 1'b0; it.fb_in = 1'b0; it.fb_out = 1'b0;
    end else if (reg_form) begin
      it.out = q_new; it.oe = !s_oe_n; it.fb_in = q_new; it.fb_out = q_new;
    end else begin
      it.out = s_pol ? sum_cmb : !sum_cmb;
      it.oe = s_pt[0];
      it.fb_in = s_pin;
      it.fb_out = s_syn ? 1'b0 : s_pin;
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares outputs shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_item_t e;
        e = sb.pop_front();
        chk(e.tag, "inner pin_out", out_a, e.out);
        chk(e.tag, "inner pin_oe", oe_a, e.oe);
        chk(e.tag, "inner fb", fb_a, e.fb_in);
        chk(e.tag, "outer pin_out", out_b, e.out);
        chk(e.tag, "outer pin_oe", oe_b, e.oe);
        chk(e.tag, "outer fb", fb_b, e.fb_out);
      end
    end
  end

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state in registered form
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset pin_out", out_a, 1'b0);
    chk("R1", "reset fb", fb_a, 1'b0);
    chk("R1", "reset pin_oe", oe_a, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    exp_q = 1'b0;

    // R3: registered sum of all terms, top term only
    drive("R3 top term", 0, 1, 0, 1, 0, 8'h80, 0, 0);
    // R4: inverted polarity, no term set
    drive("R4 active low", 0, 1, 0, 0, 0, 8'h00, 0, 0);
    // R3: term 0 is part of the registered sum (contrast with R6)
    drive("R3 term0 in sum", 0, 1, 0, 1, 0, 8'h01, 1, 0);
    // R5: shared enable pin, active low
    drive("R5 oe pin high", 0, 1, 0, 1, 1, 8'h01, 0, 0);
    drive("R4 reg low", 0, 1, 0, 1, 0, 8'h00, 0, 0);
    // R6 R7 R5: combinatorial I/O in registered mode, oe_n ignored
    drive("R6 R7 R5 cio term0", 0, 1, 1, 1, 1, 8'h01, 1, 0);
    drive("R6 R7 R4 cio low pol", 0, 1, 1, 0, 0, 8'h02, 1, 0);
    // R9: outer cell in registered mode keeps pin feedback
    drive("R9 R7 outer reg mode", 0, 1, 1, 1, 0, 8'h41, 1, 0);
    // R8 R9: complex mode, AC1 both ways
    drive("R8 R9 complex ac1=0", 1, 1, 0, 1, 0, 8'h81, 1, 0);
    drive("R8 R9 complex ac1=1", 1, 1, 1, 1, 0, 8'h81, 1, 0);
    drive("R8 R4 complex pol0", 1, 1, 0, 0, 1, 8'h00, 1, 0);
    // R2: unused cell
    drive("R2 ac0 low", 0, 0, 0, 1, 0, 8'hFF, 1, 0);
    drive("R2 ac0 low complex", 1, 0, 1, 1, 0, 8'hFF, 1, 0);

    // R10: flop holds while not registered
    drive("R3 load one", 0, 1, 0, 1, 0, 8'h10, 0, 0);
    drive("R10 complex idle", 1, 1, 0, 1, 0, 8'h00, 0, 0);
    @(negedge clk);
    syn = 1'b0; ac1 = 1'b0;
    #1;
    chk("R10", "held q after mode change", out_a, 1'b1);
    drive("R10 reload", 0, 1, 0, 1, 0, 8'h00, 0, 0);
    // R10: synchronous clear wins over load, also outside registered form
    drive("R3 load again", 0, 1, 0, 1, 0, 8'h04, 0, 0);
    drive("R10 srst in reg", 0, 1, 0, 1, 0, 8'hFF, 0, 1);
    drive("R3 load third", 0, 1, 0, 1, 0, 8'h04, 0, 0);
    drive("R10 srst in cio", 0, 1, 1, 1, 0, 8'h00, 0, 1);
    drive("R10 back to reg", 0, 1, 0, 0, 0, 8'hFF, 0, 0);

    // Random patterns across all forms
    for (int i = 0; i < 80; i++) begin
      logic [N_PT-1:0] rpt;
      rpt = N_PT'($urandom) & N_PT'($urandom);
      drive("R3 R4 R6 R7 R8 random", 1'($urandom), ($urandom % 5) != 0, 1'($urandom),
            1'($urandom), 1'($urandom), rpt, 1'($urandom), ($urandom % 9) == 0);
    end

    // R1: asynchronous reset between edges
    drive("R3 set before reset", 0, 1, 0, 1, 0, 8'h20, 0, 0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R1", "async reset pin_out", out_a, 1'b0);
    chk("R1", "async reset fb", fb_a, 1'b0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule